// File: doc/BRIEF.md
# Circular Command Word Fetcher

This block reads 32-bit command words out of a circular buffer in memory and passes them one at a time to a packet decoder further down the pipe. The buffer base address, a size code and the producer's write index come from outside the block. The block keeps the read index itself. It issues single-word reads on a simple request/response memory port and presents each returned word on a valid/ready output. When the fetch index runs past the last word of the ring, the index is masked back to the start, so a write index that sits below the read index needs no special treatment.

A batch of work starts whenever the read index and the write index differ. The write index is captured at the start of the batch and becomes the new read index once every word of the batch has been accepted downstream. While a ring batch is running, the decoder may send a jump to an indirect buffer, which is a linear run of words given by an address and a word count. The fetcher discards any word it had already fetched past the jumping packet, streams the indirect words, and then continues the ring at the first word the decoder has not yet accepted.

Top module: `cf_ring_fetch`

## Requirements
- R1: The ring holds 2^(IDX_W - size_code) words, which is 2^(27 - size_code) with the default IDX_W of 27. Every fetch index is reduced modulo that size, so with size_code 24 the word after index 7 is index 0.
- R2: The address of ring word i has bits 31:29 equal to ring_base[31:29]. Bits 28:0 are the low 29 bits of ring_base[28:0] + 4*i, and any carry out of bit 28 is dropped.
- R3: No memory request is made while the read index equals the write index. busy is low exactly when no ring or indirect fetch is in progress.
- R4: The write index is captured when a batch starts. When all words of the batch have been accepted, rd_idx takes the captured value, even if wp_idx was written again during the batch. A later write starts a new batch afterwards.
- R5: wp_max holds the largest index ever written through wp_wr and changes only on a write.
- R6: At most one memory read is outstanding, and no new request is made while an output word is waiting to be accepted.
- R7: While cmd_valid is high and cmd_ready is low, cmd_valid stays high and cmd_data stays unchanged, unless ib_go arrives.
- R8: A pulse on ib_go during a ring batch drops the held output word and any read in flight. The block then fetches exactly ib_words words from ib_addr, ib_addr+4 and so on, without wrapping, with bits 31:29 taken from ring_base. After that it resumes the ring at the first ring word not yet accepted.
- R9: ib_go has no effect while the block is idle or is already running an indirect buffer.
- R10: A write index below the read index is fetched as the words up to the end of the ring, followed by the words from index 0 up to the write index.
- R11: After reset, busy, cmd_valid and mem_req_valid are low, and rd_idx and wp_max are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_base | input | 32 | Byte address of ring word 0 |
| size_code | input | CODE_W | Ring size code (R1) |
| wp_wr | input | 1 | Write-index update strobe |
| wp_idx | input | IDX_W | New write index (word units) |
| rd_idx | output | IDX_W | Current ring read index |
| wp_max | output | IDX_W | Largest write index seen |
| ib_go | input | 1 | Start an indirect buffer |
| ib_addr | input | 32-HI_W | Low address bits of the indirect buffer |
| ib_words | input | LEN_W | Indirect buffer length in words |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Returned word |
| cmd_valid | output | 1 | Command word available |
| cmd_ready | input | 1 | Decoder accepts the word |
| cmd_data | output | 32 | Command word |
| busy | output | 1 | Fetch in progress |

## Verification
The ring is driven with a run of write indices: a plain forward batch, a short batch, a write index below the read index so the fetch wraps, a repeated index that must produce no fetch, and an almost-full wrap. These patterns separate correct modulo indexing from a linear run or an off-by-one at the ring end. The ring base is placed so that base plus offset carries out of bit 28, which shows whether the upper address bits really come from the base. Directed cases cover a stalled consumer, a second write-index update during a batch (captured end point against live end point), an indirect jump that lands while a read is already in flight (resume point and dropped word), and a jump request while the block is idle.

// File: rtl/cf_pkg.sv
package cf_pkg;
   typedef enum logic [1:0] {
      CF_IDLE = 2'd0,
      CF_RING = 2'd1,
      CF_IND  = 2'd2
   } cf_state_e;
endpackage

// File: rtl/cf_wp_track.sv
// Holds the producer write index and the largest index ever written (R5).
module cf_wp_track #(
   parameter int IDX_W = 27
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [IDX_W-1:0] val,
   output logic [IDX_W-1:0] wp_q,
   output logic [IDX_W-1:0] wp_hi
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         wp_hi <= '0;
      end else if (wr) begin
         wp_q <= val;
         if (val > wp_hi) wp_hi <= val;
      end
   end
endmodule

// File: rtl/cf_addr_gen.sv
// Word address builder: low part is start + 4*offset, high part from the ring base (R2).
module cf_addr_gen #(
   parameter int HI_W  = 3,
   parameter int OFF_W = 27
) (
   input  logic [31:0]         ring_base,
   input  logic [31-HI_W:0]    start_lo,
   input  logic [OFF_W-1:0]    word_off,
   output logic [31:0]         addr
);
   localparam int LO_W = 32 - HI_W;
   logic [LO_W-1:0] lo_sum;

   assign lo_sum = start_lo + LO_W'({word_off, 2'b00});

   generate
      if (HI_W > 0) begin : g_keep_hi
         assign addr = {ring_base[31 -: HI_W], lo_sum};
      end else begin : g_flat
         assign addr = lo_sum;
      end
   endgenerate
endmodule

// File: rtl/cf_out_hold.sv
// Single output word register with flush, valid/ready handshake (R7).
module cf_out_hold #(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] din,
   input  logic          flush,
   input  logic          ready,
   output logic          valid,
   output logic [DW-1:0] data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         data  <= '0;
      end else if (flush) begin
         valid <= 1'b0;
      end else if (load) begin
         valid <= 1'b1;
         data  <= din;
      end else if (valid && ready) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/cf_ring_fetch.sv
module cf_ring_fetch #(
   parameter int IDX_W  = 27,
   parameter int CODE_W = 5,
   parameter int LEN_W  = 16,
   parameter int HI_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       ring_base,
   input  logic [CODE_W-1:0] size_code,
   input  logic              wp_wr,
   input  logic [IDX_W-1:0]  wp_idx,
   output logic [IDX_W-1:0]  rd_idx,
   output logic [IDX_W-1:0]  wp_max,
   input  logic              ib_go,
   input  logic [31-HI_W:0]  ib_addr,
   input  logic [LEN_W-1:0]  ib_words,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [31:0]       mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [31:0]       mem_rsp_data,
   output logic              cmd_valid,
   input  logic              cmd_ready,
   output logic [31:0]       cmd_data,
   output logic              busy
);
   import cf_pkg::*;

   localparam int LO_W  = 32 - HI_W;
   localparam int OFF_W = (IDX_W > LEN_W) ? IDX_W : LEN_W;

   generate
      if (IDX_W + 2 > LO_W) begin : g_bad_idx
         $error("cf_ring_fetch: IDX_W too wide for the low address field");
      end
      if (HI_W < 0 || HI_W > 8) begin : g_bad_hi
         $error("cf_ring_fetch: HI_W out of range");
      end
      if (LEN_W < 1 || LEN_W > LO_W) begin : g_bad_len
         $error("cf_ring_fetch: LEN_W out of range");
      end
   endgenerate

   cf_state_e        state;
   logic [IDX_W-1:0] ring_mask, wp_q, wp_lim;
   logic [IDX_W-1:0] fch_idx, acc_idx, end_idx, rd_q;
   logic [IDX_W-1:0] fch_inc, acc_inc, acc_nxt;
   logic [LO_W-1:0]  ib_base;
   logic [LEN_W-1:0] ib_len, ib_fch, ib_acc, ib_acc_nxt;
   logic             pend, drop;
   logic             hs, issue, req_fire, ib_take, ld;
   logic [LO_W-1:0]  start_lo;
   logic [OFF_W-1:0] word_off;

   // Ring size from the code: 2^(IDX_W - code) words (R1)
   assign ring_mask = {IDX_W{1'b1}} >> size_code;
   assign wp_lim    = wp_q & ring_mask;

   cf_wp_track #(.IDX_W(IDX_W)) u_wp (
      .clk(clk), .rst_n(rst_n), .wr(wp_wr), .val(wp_idx),
      .wp_q(wp_q), .wp_hi(wp_max)
   );

   assign hs       = cmd_valid && cmd_ready;
   assign fch_inc  = (fch_idx + 1'b1) & ring_mask;
   assign acc_inc  = (acc_idx + 1'b1) & ring_mask;
   assign acc_nxt  = hs ? acc_inc : acc_idx;
   assign ib_acc_nxt = hs ? ib_acc + 1'b1 : ib_acc;
   assign ib_take  = ib_go && (state == CF_RING);

   always_comb begin
      issue = 1'b0;
      if (!pend && !cmd_valid) begin
         if (state == CF_RING)     issue = (fch_idx != end_idx) && !ib_go;
         else if (state == CF_IND) issue = (ib_fch != ib_len);
      end
   end

   assign req_fire      = issue && mem_req_ready;
   assign mem_req_valid = issue;
   assign start_lo      = (state == CF_IND) ? ib_base : ring_base[LO_W-1:0];
   assign word_off      = (state == CF_IND) ? OFF_W'(ib_fch) : OFF_W'(fch_idx);

   cf_addr_gen #(.HI_W(HI_W), .OFF_W(OFF_W)) u_addr (
      .ring_base(ring_base), .start_lo(start_lo), .word_off(word_off),
      .addr(mem_req_addr)
   );

   assign ld = mem_rsp_valid && pend && !drop && !ib_take;

   cf_out_hold #(.DW(32)) u_out (
      .clk(clk), .rst_n(rst_n), .load(ld), .din(mem_rsp_data),
      .flush(ib_take), .ready(cmd_ready), .valid(cmd_valid), .data(cmd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= CF_IDLE;
         fch_idx <= '0;
         acc_idx <= '0;
         end_idx <= '0;
         rd_q    <= '0;
         ib_base <= '0;
         ib_len  <= '0;
         ib_fch  <= '0;
         ib_acc  <= '0;
         pend    <= 1'b0;
         drop    <= 1'b0;
      end else begin
         if (req_fire)           pend <= 1'b1;
         else if (mem_rsp_valid) pend <= 1'b0;

         if (ib_take)            drop <= (pend && !mem_rsp_valid) || req_fire;
         else if (mem_rsp_valid) drop <= 1'b0;

         case (state)
            CF_IDLE: begin
               if (rd_q != wp_lim) begin
                  state   <= CF_RING;
                  fch_idx <= rd_q;
                  acc_idx <= rd_q;
                  end_idx <= wp_lim;
               end
            end
            CF_RING: begin
               if (req_fire) fch_idx <= fch_inc;
               if (hs)       acc_idx <= acc_inc;
               if (ib_take) begin
                  state   <= CF_IND;
                  ib_base <= ib_addr;
                  ib_len  <= ib_words;
                  ib_fch  <= '0;
                  ib_acc  <= '0;
               end else if (acc_nxt == end_idx) begin
                  state <= CF_IDLE;
                  rd_q  <= end_idx;
               end
            end
            CF_IND: begin
               if (req_fire) ib_fch <= ib_fch + 1'b1;
               if (hs)       ib_acc <= ib_acc + 1'b1;
               if (ib_acc_nxt == ib_len) begin
                  state   <= CF_RING;
                  fch_idx <= acc_idx;
               end
            end
            default: state <= CF_IDLE;
         endcase
      end
   end

   assign rd_idx = rd_q;
   assign busy   = (state != CF_IDLE);
endmodule

// File: rtl/cf_ring_fetch_chk.sv
module cf_ring_fetch_chk #(
   parameter int IDX_W = 27,
   parameter int HI_W  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mem_req_valid,
   input logic             mem_req_ready,
   input logic [HI_W-1:0]  req_hi,
   input logic [HI_W-1:0]  base_hi,
   input logic             mem_rsp_valid,
   input logic             cmd_valid,
   input logic             cmd_ready,
   input logic [31:0]      cmd_data,
   input logic             ib_go,
   input logic             busy,
   input logic [IDX_W-1:0] rd_idx,
   input logic             wp_wr,
   input logic [IDX_W-1:0] wp_idx,
   input logic [IDX_W-1:0] wp_max
);
   logic [1:0]       out_q;
   logic [IDX_W-1:0] wp_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         wp_sh <= '0;
      end else begin
         out_q <= out_q + 2'((mem_req_valid && mem_req_ready) ? 1 : 0)
                        - 2'(mem_rsp_valid ? 1 : 0);
         if (wp_wr) wp_sh <= wp_idx;
      end
   end

   a_r6_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (out_q == 2'd0 && !cmd_valid));

   a_r6_rsp_expected: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rsp_valid |-> (out_q == 2'd1));

   a_r7_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready && !ib_go) |=> (cmd_valid && $stable(cmd_data)));

   a_r2_addr_hi: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> (req_hi == base_hi));

   a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req_valid);

   a_r3_stay_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && rd_idx == wp_sh && !wp_wr) |=> !busy);

   a_r5_max_grows: assert property (@(posedge clk) disable iff (!rst_n)
      wp_wr |=> (wp_max >= $past(wp_idx)));

   a_r5_max_steady: assert property (@(posedge clk) disable iff (!rst_n)
      !wp_wr |=> $stable(wp_max));
endmodule

bind cf_ring_fetch cf_ring_fetch_chk #(.IDX_W(IDX_W), .HI_W(HI_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
   .req_hi(mem_req_addr[31 -: HI_W]), .base_hi(ring_base[31 -: HI_W]),
   .mem_rsp_valid(mem_rsp_valid),
   .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
   .ib_go(ib_go), .busy(busy), .rd_idx(rd_idx),
   .wp_wr(wp_wr), .wp_idx(wp_idx), .wp_max(wp_max)
);

// File: tb/cf_ring_fetch_tb.sv
module cf_ring_fetch_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int IDX_W = 27;
   localparam int CODE  = 24;
   localparam int SZ    = 1 << (27 - CODE);
   localparam logic [31:0] BASE = 32'h7FFF_FFF8;
   localparam logic [28:0] IBA  = 29'h1234_5670;
   localparam int WD_LIMIT = 150000;
   // {write index, expected word count} per step, ring of 8 words
   localparam logic [15:0] VEC [0:4] = '{16'h0505, 16'h0702, 16'h0203,
                                         16'h0200, 16'h0107};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wp_wr = 1'b0;
   logic [IDX_W-1:0] wp_idx = '0;
   logic [IDX_W-1:0] rd_idx, wp_max;
   logic ib_go = 1'b0;
   logic [28:0] ib_addr = IBA;
   logic [15:0] ib_words = 16'd3;
   logic mem_req_valid, mem_req_ready;
   logic [31:0] mem_req_addr;
   logic mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic cmd_valid, cmd_ready;
   logic [31:0] cmd_data;
   logic busy;

   int errors = 0, checks = 0, cyc = 0;
   int rx_n = 0, req_n = 0;
   logic [31:0] rx [0:63];

   always #(CLK_PERIOD/2) clk = ~clk;
   assign mem_req_ready = 1'b1;

   cf_ring_fetch dut_i (
      .clk(clk), .rst_n(rst_n), .ring_base(BASE), .size_code(5'(CODE)),
      .wp_wr(wp_wr), .wp_idx(wp_idx), .rd_idx(rd_idx), .wp_max(wp_max),
      .ib_go(ib_go), .ib_addr(ib_addr), .ib_words(ib_words),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_data(mem_rsp_data), .cmd_valid(cmd_valid),
      .cmd_ready(cmd_ready), .cmd_data(cmd_data), .busy(busy)
   );

   logic rdy = 1'b1;
   assign cmd_ready = rdy;

   // memory model: one-cycle latency, word content is the inverted address
   always @(posedge clk) begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
         mem_rsp_valid <= 1'b1;
         mem_rsp_data  <= ~mem_req_addr;
         req_n <= req_n + 1;
      end
      if (cmd_valid && cmd_ready && rx_n < 64) begin
         rx[rx_n] <= cmd_data;
         rx_n <= rx_n + 1;
      end
   end

   function automatic logic [31:0] ring_addr(int idx);
      logic [28:0] lo;
      lo = BASE[28:0] + 29'(idx * 4);
      return {BASE[31:29], lo};
   endfunction

   function automatic logic [31:0] ind_addr(int k);
      logic [28:0] lo;
      lo = IBA + 29'(k * 4);
      return {BASE[31:29], lo};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic write_wp(input int v);
      @(negedge clk);
      wp_wr = 1'b1;
      wp_idx = IDX_W'(v);
      @(negedge clk);
      wp_wr = 1'b0;
   endtask

   task automatic wait_done(input int total);
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         if (rx_n >= total && !busy) break;
      end
      repeat (4) @(negedge clk);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > WD_LIMIT) begin
         errors++;
         checks++;
         $display("FAIL watchdog R3 actual=%0d expected<%0d", cyc, WD_LIMIT);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int rd, base_n, r0;
      logic [31:0] d0;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(!busy && !cmd_valid && !mem_req_valid, "R11 reset flags",
          {busy, cmd_valid, mem_req_valid}, 0);
      chk(rd_idx == 0 && wp_max == 0, "R11 reset indices", rd_idx, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // table walk: R1 R2 R3 R10
      rd = 0;
      for (int v = 0; v < 5; v++) begin
         int wpv, cnt;
         wpv = int'(VEC[v][15:8]);
         cnt = int'(VEC[v][7:0]);
         base_n = rx_n;
         r0 = req_n;
         write_wp(wpv);
         wait_done(base_n + cnt);
         chk(rx_n - base_n == cnt, "R3/R10 word count", rx_n - base_n, cnt);
         if (cnt == 0) chk(req_n == r0, "R3 no fetch when equal", req_n, r0);
         for (int k = 0; k < cnt; k++)
            chk(rx[base_n + k] == ~ring_addr((rd + k) % SZ), "R1/R2 ring word",
                ~rx[base_n + k], ring_addr((rd + k) % SZ));
         chk(rd_idx == IDX_W'(wpv), "R4 read index", rd_idx, wpv);
         rd = wpv;
      end
      chk(wp_max == 7, "R5 max write index", wp_max, 7);

      // R7 / R6: stalled consumer, rd=1 -> wp=3
      rdy = 1'b0;
      base_n = rx_n;
      write_wp(3);
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (cmd_valid) break;
      end
      d0 = cmd_data;
      r0 = req_n;
      repeat (6) begin
         @(negedge clk);
         chk(cmd_valid && cmd_data == d0, "R7 held word", cmd_data, d0);
      end
      chk(req_n == r0, "R6 no request while holding", req_n, r0);
      chk(d0 == ~ring_addr(1), "R2 held word address", ~d0, ring_addr(1));
      rdy = 1'b1;
      wait_done(base_n + 2);
      chk(rx[base_n + 1] == ~ring_addr(2), "R2 carry dropped above bit 28",
          ~rx[base_n + 1], ring_addr(2));

      // R4: second write during a batch; rd=3 -> wp=6 then wp=0
      base_n = rx_n;
      write_wp(6);
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (rx_n > base_n) break;
      end
      write_wp(0);
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (!busy && rx_n >= base_n + 3) break;
      end
      chk(rd_idx == 6, "R4 captured end point", rd_idx, 6);
      wait_done(base_n + 5);
      chk(rx_n - base_n == 5, "R4 follow-on batch count", rx_n - base_n, 5);
      for (int k = 0; k < 5; k++)
         chk(rx[base_n + k] == ~ring_addr((3 + k) % SZ), "R10 wrap order",
             ~rx[base_n + k], ring_addr((3 + k) % SZ));
      chk(rd_idx == 0 && wp_max == 7, "R5 max kept", wp_max, 7);

      // R8: indirect jump after two ring words, rd=0 -> wp=5
      base_n = rx_n;
      write_wp(5);
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (rx_n >= base_n + 2) break;
      end
      ib_go = 1'b1;
      @(negedge clk);
      ib_go = 1'b0;
      wait_done(base_n + 8);
      chk(rx_n - base_n == 8, "R8 total words", rx_n - base_n, 8);
      for (int k = 0; k < 2; k++)
         chk(rx[base_n + k] == ~ring_addr(k), "R8 ring before jump",
             ~rx[base_n + k], ring_addr(k));
      for (int k = 0; k < 3; k++)
         chk(rx[base_n + 2 + k] == ~ind_addr(k), "R8 indirect word",
             ~rx[base_n + 2 + k], ind_addr(k));
      for (int k = 0; k < 3; k++)
         chk(rx[base_n + 5 + k] == ~ring_addr(2 + k), "R8 ring resume",
             ~rx[base_n + 5 + k], ring_addr(2 + k));
      chk(rd_idx == 5, "R8 read index after jump", rd_idx, 5);

      // R9: jump request while idle is ignored
      r0 = req_n;
      base_n = rx_n;
      ib_go = 1'b1;
      @(negedge clk);
      ib_go = 1'b0;
      repeat (8) begin
         @(negedge clk);
         if (busy) break;
      end
      chk(!busy && req_n == r0 && rx_n == base_n, "R9 idle jump ignored",
          req_n, r0);
      chk(rd_idx == 5, "R9 read index unchanged", rd_idx, 5);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule